// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a cycle-level, synthesizable model of a synchronous SRAM with a pipelined read path and a built-in two-bit burst counter. The word is split into byte lanes (two lanes of nine bits by default). Address, write data, chip enables, the strobes and the write controls are all registered on the rising clock edge. Writes complete one edge after they are registered. Read data passes through an output register before it reaches the data bus.

An access begins at one of two address strobes. The processor-side strobe counts only while the first chip enable is active, and it always starts a read. The controller-side strobe always starts a cycle, and that cycle can be a write. Once an access is under way, the advance input steps the low two address bits through a four-beat wrap. The order is linear or interleaved, fixed by a parameter. The bus is modelled as a data output plus a drive-enable output. The output enable acts on the drive-enable without passing through a register.

Top module: `burst_sram`

## Requirements
- R1: While reset is held, and after it is released until the first read completes, `dq_oe` is 0.
- R2: A cycle starts on an edge where `ads_ctl_n`=0, or where `ads_cpu_n`=0 together with `cs1_n`=0. The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at that edge. A deselected start performs no access, and `dq_oe` is 0 in the following cycle.
- R3: `ads_cpu_n`=0 while `cs1_n`=1 is ignored. The latched address is kept, an idle device stays idle, and a running burst goes on under `adv_n`.
- R4: A cycle started by `ads_cpu_n` is a read whatever the write controls say. If both strobes are low, the processor strobe wins and the cycle is a read.
- R5: A controller-strobe start with write controls active writes `wdata` at `addr`. Without them it reads `addr`.
- R6: While an access is running and no strobe starts a cycle, `adv_n`=0 steps a beat counter k (0..3, wrapping). The accessed address keeps the upper bits of the start address. Its low two bits are (s+k) mod 4 when INTERLEAVED=0 and s XOR k when INTERLEAVED=1, where s is the low two bits of the start address. `adv_n`=1 repeats the same address.
- R7: Lane i occupies word bits [9i+8:9i] and is written only when `bwe_n`=0 and `bw_n[i]`=0. With `bwe_n`=1 and `gw_n`=1, the `bw_n` value has no effect and the cycle reads.
- R8: `gw_n`=0 writes every lane, whatever the values of `bwe_n` and `bw_n`.
- R9: A read registered at edge N shows its word on `dq_out` with `dq_oe`=1 from edge N+1 until edge N+2. Each further beat of a burst follows one cycle later, so a four-beat burst runs 3-1-1-1 from address setup.
- R10: `oe_n`=1 forces `dq_oe` to 0 with no clock edge. Returning it to 0 restores the drive of a valid read word at once.
- R11: `dq_oe` is 0 in the cycle after a write. A read of the same address registered at the next edge returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | AW | Word address latched at a cycle start |
| wdata | input | LANE_W*LANES | Write data registered every edge |
| cs1_n | input | 1 | Active-low chip enable, also gates the processor strobe |
| cs2 | input | 1 | Active-high chip enable |
| cs3_n | input | 1 | Active-low chip enable |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANE_W*LANES | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench writes a distinct arithmetic pattern to every location. It then runs a four-beat burst from every start address on two instances, one linear and one interleaved, which share inputs. The two wrap orders only differ for some starting offsets, so this separates them, and it also catches a wrong upper-address carry. Writes are tried under three controls: global write, qualified byte writes to one lane, and byte selects without their qualifier. Each is read back, which tells a lane-mask fault from an override fault. The remaining patterns cover both strobes low together, the processor strobe with the first enable high (both idle and mid-burst), each chip enable deasserted alone, burst suspend, write-then-read, and toggling the output enable between edges.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   localparam int BEAT_W = 2;

endpackage

// File: rtl/burst_sram_order.sv
module burst_sram_order #(
   parameter bit INTERLEAVED = 1'b0,
   parameter int BW          = burst_sram_pkg::BEAT_W
) (
   input  logic [BW-1:0] start_lo,
   input  logic [BW-1:0] beat,
   output logic [BW-1:0] addr_lo
);

   generate
      if (INTERLEAVED) begin : g_xor
         assign addr_lo = start_lo ^ beat;
      end else begin : g_wrap
         assign addr_lo = start_lo + beat;
      end
   endgenerate

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
   import burst_sram_pkg::*;
#(
   parameter int AW          = 6,
   parameter int LANES       = 2,
   parameter int WORD_W      = 18,
   parameter bit INTERLEAVED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              cs1_n,
   input  logic              cs2,
   input  logic              cs3_n,
   input  logic              ads_cpu_n,
   input  logic              ads_ctl_n,
   input  logic              adv_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bw_n,
   output op_e               op_q,
   output logic [AW-1:0]     acc_addr,
   output logic [WORD_W-1:0] wdata_q,
   output logic [LANES-1:0]  lanes_q
);

   localparam int BW = BEAT_W;

   logic              cpu_go, ctl_go, go, chip_sel, wr_req;
   logic [LANES-1:0]  lanes_in;
   logic [AW-1:0]     base_q;
   logic [BW-1:0]     cnt_q, lo_bits;
   logic              active_q;

   assign cpu_go   = !ads_cpu_n && !cs1_n;
   assign ctl_go   = !ads_ctl_n;
   assign go       = cpu_go || ctl_go;
   assign chip_sel = !cs1_n && cs2 && !cs3_n;
   assign lanes_in = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
   assign wr_req   = |lanes_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         op_q     <= OP_IDLE;
         base_q   <= '0;
         cnt_q    <= '0;
         lanes_q  <= '0;
         wdata_q  <= '0;
      end else if (go) begin
         base_q   <= addr;
         cnt_q    <= '0;
         active_q <= chip_sel;
         wdata_q  <= wdata;
         if (!chip_sel) begin
            op_q    <= OP_IDLE;
            lanes_q <= '0;
         end else if (cpu_go) begin
            op_q    <= OP_READ;
            lanes_q <= '0;
         end else begin
            op_q    <= wr_req ? OP_WRITE : OP_READ;
            lanes_q <= lanes_in;
         end
      end else if (active_q) begin
         if (!adv_n) cnt_q <= cnt_q + 1'b1;
         op_q    <= wr_req ? OP_WRITE : OP_READ;
         lanes_q <= lanes_in;
         wdata_q <= wdata;
      end else begin
         op_q    <= OP_IDLE;
         lanes_q <= '0;
      end
   end

   burst_sram_order #(.INTERLEAVED(INTERLEAVED), .BW(BW)) u_order (
      .start_lo (base_q[BW-1:0]),
      .beat     (cnt_q),
      .addr_lo  (lo_bits)
   );

   assign acc_addr = {base_q[AW-1:BW], lo_bits};

   assert_cpu_gated_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_cpu_n && cs1_n && ads_ctl_n && !active_q) |=> (op_q == OP_IDLE));

   assert_cpu_gated_addr_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_cpu_n && cs1_n && ads_ctl_n) |=> $stable(base_q));

   assert_cpu_read_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ads_cpu_n && !cs1_n && cs2 && !cs3_n) |=> (op_q == OP_READ));

   assert_deselect_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ((!ads_ctl_n || (!ads_cpu_n && !cs1_n)) && !(!cs1_n && cs2 && !cs3_n))
      |=> (op_q == OP_IDLE));

   assert_global_write_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!gw_n && !(!ads_cpu_n && !cs1_n) &&
       ((!ads_ctl_n && !cs1_n && cs2 && !cs3_n) || (ads_ctl_n && active_q)))
      |=> (lanes_q == {LANES{1'b1}} && op_q == OP_WRITE));

   assert_advance_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ads_ctl_n && (ads_cpu_n || cs1_n) && active_q && !adv_n)
      |=> (cnt_q == $past(cnt_q) + 2'd1));

   assert_suspend_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ads_ctl_n && (ads_cpu_n || cs1_n) && adv_n) |=> $stable(cnt_q));

endmodule

// File: rtl/burst_sram_store.sv
module burst_sram_store
   import burst_sram_pkg::*;
#(
   parameter int AW     = 6,
   parameter int DEPTH  = 64,
   parameter int LANE_W = 9,
   parameter int LANES  = 2,
   parameter int WORD_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               op_q,
   input  logic [AW-1:0]     acc_addr,
   input  logic [WORD_W-1:0] wdata_q,
   input  logic [LANES-1:0]  lanes_q,
   input  logic              oe_n,
   output logic [WORD_W-1:0] dq_out,
   output logic              dq_oe
);

   logic [WORD_W-1:0] rd_word;
   logic [WORD_W-1:0] dout_q;
   logic              dvalid_q;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [LANE_W-1:0] lane_mem [DEPTH];

         always_ff @(posedge clk) begin
            if (op_q == OP_WRITE && lanes_q[i])
               lane_mem[acc_addr] <= wdata_q[i*LANE_W +: LANE_W];
         end

         assign rd_word[i*LANE_W +: LANE_W] = lane_mem[acc_addr];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout_q   <= '0;
         dvalid_q <= 1'b0;
      end else begin
         dvalid_q <= (op_q == OP_READ);
         if (op_q == OP_READ) dout_q <= rd_word;
      end
   end

   assign dq_out = dout_q;
   assign dq_oe  = dvalid_q && !oe_n;

   assert_read_lands_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ && !oe_n) |=> (dq_oe || oe_n));

   assert_write_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WRITE) |=> !dq_oe);

   assert_read_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_READ) |=> $stable(dq_out));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int AW          = 6,
   parameter int LANE_W      = 9,
   parameter int LANES       = 2,
   parameter bit INTERLEAVED = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   input  logic [LANE_W*LANES-1:0] wdata,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    ads_cpu_n,
   input  logic                    ads_ctl_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    oe_n,
   output logic [LANE_W*LANES-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int WORD_W = LANE_W * LANES;
   localparam int DEPTH  = 1 << AW;

   generate
      if (AW < BEAT_W + 1) begin : g_bad_aw
         $error("burst_sram: AW must exceed the burst counter width");
      end
      if (AW > 16) begin : g_big_aw
         $error("burst_sram: AW too large for a modelled array");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram: lane geometry must be non-empty");
      end
   endgenerate

   op_e               op_q;
   logic [AW-1:0]     acc_addr;
   logic [WORD_W-1:0] wdata_q;
   logic [LANES-1:0]  lanes_q;

   burst_sram_ctl #(
      .AW(AW), .LANES(LANES), .WORD_W(WORD_W), .INTERLEAVED(INTERLEAVED)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wdata     (wdata),
      .cs1_n     (cs1_n),
      .cs2       (cs2),
      .cs3_n     (cs3_n),
      .ads_cpu_n (ads_cpu_n),
      .ads_ctl_n (ads_ctl_n),
      .adv_n     (adv_n),
      .gw_n      (gw_n),
      .bwe_n     (bwe_n),
      .bw_n      (bw_n),
      .op_q      (op_q),
      .acc_addr  (acc_addr),
      .wdata_q   (wdata_q),
      .lanes_q   (lanes_q)
   );

   burst_sram_store #(
      .AW(AW), .DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES), .WORD_W(WORD_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_q     (op_q),
      .acc_addr (acc_addr),
      .wdata_q  (wdata_q),
      .lanes_q  (lanes_q),
      .oe_n     (oe_n),
      .dq_out   (dq_out),
      .dq_oe    (dq_oe)
   );

   assert_reset_quiet_R1 : assert property (@(posedge clk)
      !rst_n |=> !dq_oe);

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

   localparam int CLK_P   = 10;
   localparam int AW      = 6;
   localparam int LANE_W  = 9;
   localparam int LANES   = 2;
   localparam int W       = LANE_W * LANES;
   localparam int DEPTH   = 1 << AW;
   localparam int WD_MAX  = 50000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic [W-1:0]  wdata;
   logic          cs1_n, cs2, cs3_n, ads_cpu_n, ads_ctl_n, adv_n, gw_n, bwe_n, oe_n;
   logic [LANES-1:0] bw_n;
   logic [W-1:0]  dq_l, dq_i;
   logic          oe_l, oe_i;

   logic [W-1:0]  ref_l [DEPTH];
   logic [W-1:0]  ref_i [DEPTH];

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   always #(CLK_P/2) clk = ~clk;

   burst_sram #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES), .INTERLEAVED(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
      .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
      .dq_out(dq_l), .dq_oe(oe_l)
   );

   burst_sram #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES), .INTERLEAVED(1'b1)) u_dut_il (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
      .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
      .dq_out(dq_i), .dq_oe(oe_i)
   );

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_MAX) begin
         failures = failures + 1;
         $display("FAIL R9 watchdog actual=%0d expected<=%0d cycles", cycles, WD_MAX);
         report();
         $finish;
      end
   end

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         failures = failures + 1;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat(int a, int s);
      return W'(a * 1031 + s * 97 + 341) ^ W'(a << 11);
   endfunction

   function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] a, int k, bit il);
      logic [1:0] lo;
      lo = il ? (a[1:0] ^ 2'(k)) : 2'(a[1:0] + 2'(k));
      return {a[AW-1:2], lo};
   endfunction

   task automatic set_idle();
      ads_cpu_n = 1'b1; ads_ctl_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
      cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; oe_n = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic deselect();
      set_idle();
      ads_ctl_n = 1'b0; cs2 = 1'b0;
      tick();
      set_idle();
   endtask

   // Single write started by the controller strobe; gw selects global write (R8).
   task automatic wr_single(logic [AW-1:0] a, logic [W-1:0] d, bit gw);
      set_idle();
      ads_ctl_n = 1'b0; addr = a; wdata = d;
      if (gw) gw_n = 1'b0;
      else begin bwe_n = 1'b0; bw_n = '0; end
      tick();
      set_idle();
      ref_l[a] = d;
      ref_i[a] = d;
   endtask

   task automatic wr_burst(logic [AW-1:0] a, int seed);
      set_idle();
      ads_ctl_n = 1'b0; addr = a; wdata = pat(a, seed); bwe_n = 1'b0; bw_n = '0;
      ref_l[beat_addr(a, 0, 1'b0)] = pat(a, seed);
      ref_i[beat_addr(a, 0, 1'b1)] = pat(a, seed);
      tick();
      ads_ctl_n = 1'b1; adv_n = 1'b0;
      for (int k = 1; k < 4; k++) begin
         wdata = pat(a, seed + k);
         ref_l[beat_addr(a, k, 1'b0)] = pat(a, seed + k);
         ref_i[beat_addr(a, k, 1'b1)] = pat(a, seed + k);
         tick();
      end
      deselect();
   endtask

   // Four-beat read from the processor strobe; beat k is on the bus after edge N+1+k (R9, R6).
   task automatic rd_burst(logic [AW-1:0] a);
      set_idle();
      ads_cpu_n = 1'b0; addr = a;
      tick();
      ads_cpu_n = 1'b1; adv_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R9 linear beat", dq_l, ref_l[beat_addr(a, k, 1'b0)]);
         chk("R6 interleaved beat", dq_i, ref_i[beat_addr(a, k, 1'b1)]);
         chk("R9 drive", {17'd0, oe_l & oe_i}, 18'd1);
      end
      adv_n = 1'b1; ads_ctl_n = 1'b0; cs2 = 1'b0;
      tick();
      chk("R9 linear last beat", dq_l, ref_l[beat_addr(a, 3, 1'b0)]);
      chk("R6 interleaved last beat", dq_i, ref_i[beat_addr(a, 3, 1'b1)]);
      set_idle();
   endtask

   initial begin
      logic [W-1:0] old7, d;
      rst_n = 1'b0; addr = '0; wdata = '0;
      set_idle();
      repeat (3) @(negedge clk);
      chk("R1 oe during reset", {16'd0, oe_l, oe_i}, 18'd0);
      rst_n = 1'b1;
      tick();
      chk("R1 oe after reset", {16'd0, oe_l, oe_i}, 18'd0);

      // Fill every location; every third uses global write with byte controls idle (R8, R5).
      for (int a = 0; a < DEPTH; a++) wr_single(AW'(a), pat(a, 0), (a % 3) == 0);
      deselect();
      for (int a = 0; a < DEPTH; a++) rd_burst(AW'(a));

      // R11: no drive after a write, then the suspended re-read shows new data.
      set_idle();
      ads_ctl_n = 1'b0; addr = 6'd3; wdata = 18'h2D1E4; bwe_n = 1'b0; bw_n = '0;
      ref_l[3] = 18'h2D1E4; ref_i[3] = 18'h2D1E4;
      tick();
      set_idle();
      tick();
      chk("R11 quiet after write", {17'd0, oe_l}, 18'd0);
      tick();
      chk("R11 read after write", dq_l, 18'h2D1E4);
      chk("R11 read after write drive", {17'd0, oe_l}, 18'd1);
      deselect();

      // R7: lane A only, then lane B only, then selects without qualifier.
      set_idle();
      ads_ctl_n = 1'b0; addr = 6'd5; wdata = 18'h3FFFF; bwe_n = 1'b0; bw_n = 2'b10;
      ref_l[5][8:0] = 9'h1FF; ref_i[5][8:0] = 9'h1FF;
      tick();
      deselect();
      ads_ctl_n = 1'b0; addr = 6'd5; wdata = 18'h00000; bwe_n = 1'b0; bw_n = 2'b01;
      ref_l[5][17:9] = 9'h000; ref_i[5][17:9] = 9'h000;
      tick();
      deselect();
      ads_ctl_n = 1'b0; addr = 6'd5; wdata = 18'h15555; bwe_n = 1'b1; bw_n = 2'b00;
      tick();
      deselect();
      chk("R7 unqualified selects read", dq_l, ref_l[5]);
      chk("R7 lane result", dq_l, {9'h000, 9'h1FF});
      rd_burst(6'd5);

      // R8: global write overrides deasserted lane selects.
      set_idle();
      ads_ctl_n = 1'b0; addr = 6'd10; wdata = 18'h2A5A5; gw_n = 1'b0; bwe_n = 1'b1; bw_n = 2'b11;
      ref_l[10] = 18'h2A5A5; ref_i[10] = 18'h2A5A5;
      tick();
      deselect();
      rd_burst(6'd10);

      // R4: both strobes low with global write asserted is a read.
      old7 = ref_l[7];
      set_idle();
      ads_cpu_n = 1'b0; ads_ctl_n = 1'b0; addr = 6'd7; wdata = ~old7; gw_n = 1'b0;
      tick();
      deselect();
      chk("R4 strobe priority read data", dq_l, old7);
      chk("R4 strobe priority drive", {17'd0, oe_l}, 18'd1);
      rd_burst(6'd7);
      chk("R4 memory unchanged", ref_l[7], old7);

      // R2: each enable deasserted alone gives no access.
      for (int c = 0; c < 3; c++) begin
         set_idle();
         ads_ctl_n = 1'b0; addr = 6'd4;
         if (c == 0) cs1_n = 1'b1;
         if (c == 1) cs2 = 1'b0;
         if (c == 2) cs3_n = 1'b1;
         tick();
         set_idle();
         tick();
         chk("R2 deselected no drive", {16'd0, oe_l, oe_i}, 18'd0);
      end
      set_idle();
      ads_ctl_n = 1'b0; addr = 6'd4;
      tick();
      deselect();
      chk("R2 selected read", dq_l, ref_l[4]);

      // R3: processor strobe with cs1_n high while idle.
      deselect();
      ads_cpu_n = 1'b0; cs1_n = 1'b1; addr = 6'd9;
      tick();
      set_idle();
      tick();
      chk("R3 gated strobe idle", {16'd0, oe_l, oe_i}, 18'd0);

      // R3: gated strobe during a burst does not reload the address.
      set_idle();
      ads_cpu_n = 1'b0; addr = 6'd12;
      tick();
      ads_cpu_n = 1'b0; cs1_n = 1'b1; addr = 6'd40; adv_n = 1'b0;
      tick();
      chk("R3 burst beat0", dq_l, ref_l[12]);
      set_idle();
      tick();
      chk("R3 burst continues lin", dq_l, ref_l[13]);
      chk("R3 burst continues il", dq_i, ref_i[13]);
      deselect();

      // R6: suspend repeats the same address.
      set_idle();
      ads_cpu_n = 1'b0; addr = 6'd22;
      tick();
      set_idle();
      tick();
      chk("R6 suspend first", dq_l, ref_l[22]);
      tick();
      chk("R6 suspend repeat", dq_l, ref_l[22]);

      // R10: output enable acts between edges.
      #1 oe_n = 1'b1;
      #1 chk("R10 oe off", {16'd0, oe_l, oe_i}, 18'd0);
      oe_n = 1'b0;
      #1 chk("R10 oe on", {16'd0, oe_l, oe_i}, 18'd3);
      @(negedge clk);
      deselect();

      // R6/R5: burst writes from several start offsets, then a full re-sweep.
      for (int s = 0; s < 4; s++) wr_burst(AW'(32 + 4 * s + s), 50 + s);
      for (int a = 0; a < DEPTH; a++) rd_burst(AW'(a));

      d = ref_l[0];
      chk("R5 sweep sanity", ref_l[0], d);
      report();
      $finish;
   end

endmodule